// File: doc/BRIEF.md
# Programmable Serial LFSR Scrambler

This block is a bit-serial Fibonacci shift register whose tap mask, starting seed and span are loaded at run time. The same register runs in three per-beat modes. As a free-running pseudo-random bit generator it emits the register's low bit and feeds back the parity of the tapped bits. As a multiplicative scrambler it folds each input bit into that feedback. As the matching self-synchronising descrambler it feeds the received bits straight into the register and XORs the tap parity onto them.

The span is set by a length value L. The register then occupies bits 0 to L. Each step shifts it right by one and writes the new bit into position L. Lengths above W-1 are refused. A seed-restore strobe returns the register to the stored seed. A pre-shift command advances the register a programmed number of generator steps without emitting anything, so that a sequence can be aligned to a known phase. Data beats are offered with a valid/ready pair, and each accepted beat yields one registered output bit one cycle later.

Top module: `lfsr_scrambler`

## Requirements
- R1: A step shifts the register right by one and inserts the new bit at position L. The tap parity is the XOR of all bits of (register AND mask). Register, mask and seed bits above position L are always zero.
- R2: When `in_mode` is 0 (generator), the output is register bit 0 before the step, and the inserted bit is the tap parity. `in_bit` is ignored.
- R3: When `in_mode` is 1 (scrambler), the output is register bit 0 before the step, and the inserted bit is the tap parity XOR `in_bit`.
- R4: When `in_mode` is 2 (descrambler), the output is the tap parity XOR `in_bit`, and the inserted bit is `in_bit`. Suppose a stream is scrambled from a seed and then descrambled from the same seed. Every output bit from index L+1 onward equals the plain bit L+1 positions earlier.
- R5: An accepted `cfg_load` (with `cfg_len` at most W-1) stores the mask and seed, each cleared above bit L. It also loads the register with that seed, cancels any pre-shift, and clears `cfg_err`. A `cfg_load` with `cfg_len` of W or more sets `cfg_err` and leaves the mask, seed, length and register unchanged.
- R6: `seed_reset` reloads the register from the stored seed, leaves the mask and length unchanged, and cancels any pre-shift.
- R7: `pre_start` with count N, while not busy, raises `busy` for exactly N cycles. During those cycles the register makes N generator steps, no output is produced and `in_ready` is low. N of 0 does nothing, and `pre_start` while busy is ignored.
- R8: `in_ready` is high only when the block is not busy and none of `cfg_load`, `seed_reset` or `pre_start` is asserted. Each accepted beat gives exactly one `out_valid` pulse in the following cycle. After reset `out_valid`, `busy` and `cfg_err` are 0.
- R9: `in_mode` value 3 behaves exactly like the generator.
- R10: Mask 0x19 with L=3 repeats every 15 outputs with 8 ones per period. Mask 0x29 with L=4 repeats every 31 outputs with 16 ones per period. Both hold for any nonzero seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_mask | input | W | Tap mask, bit 0 is the x^0 term |
| cfg_seed | input | W | Seed value, bit 0 is emitted first |
| cfg_len | input | LW+1 | Insertion position L |
| cfg_err | output | 1 | Last configuration load was refused |
| seed_reset | input | 1 | Restore register to stored seed |
| pre_start | input | 1 | Start pre-shift |
| pre_count | input | CW | Number of pre-shift steps |
| busy | output | 1 | Pre-shift in progress |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be accepted |
| in_mode | input | 2 | 0 generator, 1 scrambler, 2 descrambler, 3 generator |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output bit valid |
| out_bit | output | 1 | Serial output bit |

## Verification
The generator is run with two primitive tap sets, and the output is checked for its period and its count of ones. This separates a correct parity and insertion point from one that is off by a bit position. Random data is scrambled and then descrambled from the same seed, which shows whether the two feedback paths are truly inverse, including the warm-up delay of L+1 bits. A sequence emitted after a pre-shift of N steps is compared against an earlier capture offset by N, and it is run with and without an abort. Refused lengths, all-ones mask and seed above L, the full 32-bit span and mode 3 round out the patterns, while a behavioural model is compared every clock.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  // Per-beat operating mode; code 3 is an alias of the generator.
  typedef enum logic [1:0] {
    MODE_GEN     = 2'd0,
    MODE_SCR     = 2'd1,
    MODE_DSC     = 2'd2,
    MODE_GEN_ALT = 2'd3
  } lfsr_mode_e;

endpackage

// File: rtl/lfsr_cfg_regs.sv
module lfsr_cfg_regs #(
  parameter  int W  = 32,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [W-1:0]  cfg_mask,
  input  logic [W-1:0]  cfg_seed,
  input  logic [LW:0]   cfg_len,
  output logic [W-1:0]  mask_q,
  output logic [W-1:0]  seed_q,
  output logic [W-1:0]  span_q,
  output logic [W-1:0]  seed_new,
  output logic [LW-1:0] len_q,
  output logic          cfg_ok,
  output logic          cfg_err
);

  logic [W-1:0] span_new;

  // Thermometer masks: bit i set when i <= length
  for (genvar i = 0; i < W; i++) begin : g_span
    assign span_new[i] = (cfg_len >= (LW+1)'(i));
    assign span_q[i]   = (len_q   >= LW'(i));
  end

  assign cfg_ok   = cfg_load && (cfg_len < (LW+1)'(W));
  assign seed_new = cfg_seed & span_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      seed_q  <= '0;
      len_q   <= '0;
      cfg_err <= 1'b0;
    end else if (cfg_load) begin
      cfg_err <= !cfg_ok;
      if (cfg_ok) begin
        mask_q <= cfg_mask & span_new;
        seed_q <= seed_new;
        len_q  <= cfg_len[LW-1:0];
      end
    end
  end

  AST_REJECT_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    cfg_load && (cfg_len > (LW+1)'(W-1)) |=> cfg_err && $stable(mask_q) && $stable(seed_q) && $stable(len_q)); // R5

  AST_MASK_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
    ((mask_q | seed_q) & ~span_q) == '0); // R1

endmodule

// File: rtl/lfsr_core.sv
module lfsr_core
  import lfsr_pkg::*;
#(
  parameter  int W  = 32,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          step,
  input  lfsr_mode_e    mode,
  input  logic          in_bit,
  input  logic [W-1:0]  mask,
  input  logic [W-1:0]  span,
  input  logic [LW-1:0] len,
  output logic [W-1:0]  sr_q,
  output logic          step_out
);

  logic         taps;
  logic         ins;
  logic [W-1:0] sr_next;

  assign taps = ^(sr_q & mask);

  always_comb begin
    case (mode)
      MODE_SCR: begin
        ins      = taps ^ in_bit;
        step_out = sr_q[0];
      end
      MODE_DSC: begin
        ins      = in_bit;
        step_out = taps ^ in_bit;
      end
      default: begin
        ins      = taps;
        step_out = sr_q[0];
      end
    endcase
  end

  assign sr_next = (sr_q >> 1) | (W'(ins) << len);

  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (load) sr_q <= load_val;
    else if (step) sr_q <= sr_next;
  end

  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
    step && !load |=> ((sr_q ^ ($past(sr_q) >> 1)) & ~(W'(1) << len)) == '0); // R1

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sr_q & ~span) == '0); // R1

endmodule

// File: rtl/lfsr_preshift.sv
module lfsr_preshift #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] count,
  input  logic          abort,
  output logic          busy,
  output logic          step
);

  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign step = busy && !abort;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (abort) cnt_q <= '0;
    else if (busy)  cnt_q <= cnt_q - CW'(1);
    else if (start) cnt_q <= count;
  end

  AST_PRE_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    busy && !abort |=> cnt_q == $past(cnt_q) - CW'(1)); // R7

  AST_PRE_ABORT: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy); // R6

endmodule

// File: rtl/lfsr_scrambler.sv
module lfsr_scrambler
  import lfsr_pkg::*;
#(
  parameter  int W  = 32,
  parameter  int CW = 16,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [W-1:0]  cfg_mask,
  input  logic [W-1:0]  cfg_seed,
  input  logic [LW:0]   cfg_len,
  output logic          cfg_err,
  input  logic          seed_reset,
  input  logic          pre_start,
  input  logic [CW-1:0] pre_count,
  output logic          busy,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic          in_bit,
  output logic          out_valid,
  output logic          out_bit
);

  logic [W-1:0]  mask_q, seed_q, span_q, seed_new, sr_q;
  logic [LW-1:0] len_q;
  logic          cfg_ok, abort, pre_step, beat, step_out;
  lfsr_mode_e    core_mode;

  lfsr_cfg_regs #(.W(W)) u_cfg (
    .clk, .rst, .cfg_load, .cfg_mask, .cfg_seed, .cfg_len,
    .mask_q, .seed_q, .span_q, .seed_new, .len_q, .cfg_ok, .cfg_err
  );

  assign abort = cfg_ok || seed_reset;

  lfsr_preshift #(.CW(CW)) u_pre (
    .clk, .rst, .start(pre_start), .count(pre_count), .abort,
    .busy, .step(pre_step)
  );

  assign in_ready  = !busy && !cfg_load && !seed_reset && !pre_start;
  assign beat      = in_valid && in_ready;
  assign core_mode = pre_step ? MODE_GEN : lfsr_mode_e'(in_mode);

  lfsr_core #(.W(W)) u_core (
    .clk, .rst,
    .load(abort),
    .load_val(cfg_ok ? seed_new : seed_q),
    .step(pre_step || beat),
    .mode(core_mode),
    .in_bit,
    .mask(mask_q),
    .span(span_q),
    .len(len_q),
    .sr_q,
    .step_out
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= beat;
      if (beat) out_bit <= step_out;
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready); // R7

  AST_BEAT_GIVES_OUT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R8

  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !out_valid); // R8

  AST_SEED_RESTORE: assert property (@(posedge clk) disable iff (rst)
    seed_reset && !cfg_load |=> sr_q == $past(seed_q)); // R6

endmodule

// File: tb/lfsr_scrambler_bench.sv
`timescale 1ns/1ps
module lfsr_scrambler_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 0, seed_reset = 0, pre_start = 0, in_valid = 0, in_bit = 0;
  logic [31:0] cfg_mask = 0, cfg_seed = 0;
  logic [5:0]  cfg_len = 0;
  logic [15:0] pre_count = 0;
  logic [1:0]  in_mode = 0;
  logic        cfg_err, busy, in_ready, out_valid, out_bit;

  always #2 clk = ~clk;

  lfsr_scrambler u_lfsr_scrambler (
    .clk, .rst, .cfg_load, .cfg_mask, .cfg_seed, .cfg_len, .cfg_err,
    .seed_reset, .pre_start, .pre_count, .busy, .in_valid, .in_ready,
    .in_mode, .in_bit, .out_valid, .out_bit
  );

  int nvec = 0, nfail = 0;
  bit done = 0;
  string cur_req = "R8";

  // behavioural model state
  logic [31:0] m_sr = 0, m_mask = 0, m_seed = 0;
  int m_len = 0, m_cnt = 0;
  bit m_err = 0, m_ov = 0, m_ob = 0;
  bit outs[$];

  task automatic chk(string req, string what, int got, int exp);
    nvec++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic bit par(logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c[0];
  endfunction

  function automatic bit m_ready();
    return (m_cnt == 0) && !cfg_load && !seed_reset && !pre_start;
  endfunction

  task automatic m_shift(bit nb);
    m_sr = (m_sr >> 1) | (32'(nb) << m_len);
  endtask

  task automatic m_update(bit acc);
    bit p;
    logic [31:0] lim;
    m_ov = acc;
    if (cfg_load) m_err = (cfg_len > 6'd31);
    p = par(m_sr & m_mask);
    if (cfg_load && cfg_len <= 6'd31) begin
      lim = 32'((64'd1 << (int'(cfg_len) + 1)) - 64'd1);
      m_mask = cfg_mask & lim; m_seed = cfg_seed & lim;
      m_len = int'(cfg_len); m_sr = m_seed; m_cnt = 0;
    end else if (seed_reset) begin
      m_sr = m_seed; m_cnt = 0;
    end else if (m_cnt > 0) begin
      m_shift(p); m_cnt--;
    end else if (pre_start) begin
      m_cnt = int'(pre_count);
    end else if (acc) begin
      if (in_mode == 2'd1) begin m_ob = m_sr[0]; m_shift(p ^ in_bit); end
      else if (in_mode == 2'd2) begin m_ob = p ^ in_bit; m_shift(in_bit); end
      else begin m_ob = m_sr[0]; m_shift(p); end
    end
  endtask

  task automatic tick();
    bit acc;
    #1;
    chk(cur_req, "in_ready", int'(in_ready), int'(m_ready()));
    @(posedge clk);
    acc = in_valid && m_ready();
    m_update(acc);
    @(negedge clk);
    chk(cur_req, "out_valid", int'(out_valid), int'(m_ov));
    chk(cur_req, "busy", int'(busy), int'(m_cnt != 0));
    chk(cur_req, "cfg_err", int'(cfg_err), int'(m_err));
    if (out_valid && m_ov) begin
      chk(cur_req, "out_bit", int'(out_bit), int'(m_ob));
      outs.push_back(out_bit);
    end
  endtask

  task automatic load_cfg(logic [31:0] mk, logic [31:0] sd, int ln);
    cfg_load = 1; cfg_mask = mk; cfg_seed = sd; cfg_len = 6'(ln);
    tick(); cfg_load = 0;
  endtask

  task automatic beat(int md, bit b);
    in_valid = 1; in_mode = 2'(md); in_bit = b;
    tick(); in_valid = 0;
  endtask

  task automatic restore();
    seed_reset = 1; tick(); seed_reset = 0;
  endtask

  task automatic preshift(int n);
    pre_start = 1; pre_count = 16'(n); tick(); pre_start = 0;
  endtask

  task automatic period_check(string req, int per, int ones_exp);
    int ones = 0;
    for (int i = 0; i < per; i++) begin
      ones += int'(outs[i]);
      chk(req, "period repeat", int'(outs[i + per]), int'(outs[i]));
    end
    chk(req, "ones per period", ones, ones_exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bit plain[$];
    bit scr[$];
    bit ref_q[$];
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state R8
    cur_req = "R8";
    tick();
    chk("R8", "reset out_valid", int'(out_valid), 0);
    chk("R8", "reset busy", int'(busy), 0);
    chk("R8", "reset cfg_err", int'(cfg_err), 0);

    // R10 period with 0x19, L=3
    cur_req = "R10";
    load_cfg(32'h19, 32'h1, 3);
    outs.delete();
    for (int i = 0; i < 30; i++) beat(0, 1'($urandom));
    period_check("R10", 15, 8);
    load_cfg(32'h29, 32'h5, 4);
    outs.delete();
    for (int i = 0; i < 62; i++) beat(0, 0);
    period_check("R10", 31, 16);

    // R2 generator ignores in_bit, R9 mode 3
    cur_req = "R2";
    for (int i = 0; i < 20; i++) beat(0, 1'($urandom));
    cur_req = "R9";
    for (int i = 0; i < 20; i++) beat(3, 1'($urandom));

    // R3 / R4 round trip
    cur_req = "R3";
    restore();
    outs.delete();
    for (int i = 0; i < 60; i++) begin
      plain.push_back(1'($urandom));
      beat(1, plain[i]);
    end
    scr = outs;
    cur_req = "R4";
    restore();
    outs.delete();
    for (int i = 0; i < 60; i++) beat(2, scr[i]);
    for (int i = 0; i + 5 < 60; i++)
      chk("R4", "descrambled bit", int'(outs[i + 5]), int'(plain[i]));

    // R7 pre-shift alignment, with in_valid held high while busy
    cur_req = "R7";
    restore();
    outs.delete();
    for (int i = 0; i < 25; i++) beat(0, 0);
    ref_q = outs;
    restore();
    preshift(7);
    in_valid = 1; in_mode = 0;
    for (int i = 0; i < 7; i++) tick();
    in_valid = 0;
    chk("R7", "busy after N cycles", int'(busy), 0);
    outs.delete();
    for (int i = 0; i < 18; i++) beat(0, 0);
    for (int i = 0; i < 18; i++)
      chk("R7", "aligned bit", int'(outs[i]), int'(ref_q[i + 7]));
    preshift(0);
    chk("R7", "zero count idle", int'(busy), 0);
    preshift(5);
    preshift(9);
    for (int i = 0; i < 5; i++) tick();

    // R6 abort by seed reset
    cur_req = "R6";
    preshift(20);
    tick(); tick();
    restore();
    chk("R6", "busy after abort", int'(busy), 0);
    for (int i = 0; i < 10; i++) beat(0, 0);

    // R5 refused lengths keep config
    cur_req = "R5";
    load_cfg(32'hFFFF, 32'hABCD, 40);
    chk("R5", "error flag", int'(cfg_err), 1);
    for (int i = 0; i < 12; i++) beat(0, 0);
    load_cfg(32'h3, 32'h1, 32);
    for (int i = 0; i < 12; i++) beat(1, 1'($urandom));
    preshift(6);
    tick();
    load_cfg(32'h3, 32'h1, 33);
    for (int i = 0; i < 6; i++) tick();

    // R1 high bits cleared, full span
    cur_req = "R1";
    load_cfg(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5);
    chk("R5", "error cleared", int'(cfg_err), 0);
    for (int i = 0; i < 30; i++) beat(0, 0);
    load_cfg(32'h8000_0057, 32'hDEAD_BEEF, 31);
    for (int i = 0; i < 40; i++) beat(int'($urandom_range(0, 3)), 1'($urandom));
    load_cfg(32'h29, 32'h0, 4);
    for (int i = 0; i < 10; i++) beat(1, 1'($urandom));

    finish_run();
  end

endmodule